// File: doc/BRIEF.md
# Three-Wire Codec Configuration Serializer

This block is the master side of a three-line control link (serial clock, serial data and a phase-select "mode" line) used to program an audio codec. A host presents one byte request at a time. The request is either an address byte, which the block builds from a fixed device address and a two-bit type, or a data byte, which is sent as given. A data byte can carry a halt flag. The block then runs the whole byte on the lines without further help and signals completion.

Every minimum time on the link is a cycle count that the block derives from a clock-frequency parameter. Each count is rounded up, so the minimum times hold at any clock rate. The link idles with the mode and clock lines high. The mode line marks the phase: it is held low across an address byte and high across a data byte. Bits leave least significant first. The codec samples each bit on the rising edge of the serial clock. A halt puts a low pulse on the mode line before a data byte.

Top module: `cfg3w_master`

## Requirements
- R1: Out of reset and whenever `busy` is 0, the lines sit at idle: `serMode`=1, `serClk`=1, `serData`=0.
- R2: An address request (`isData`=0) drives `serMode` low with `serClk` high and `serData` low for SETUP_CYC cycles before the first falling clock. `serMode` stays low through all eight bits.
- R3: The address byte sent is {DEV_ADDR, payload[1:0]}, with DEV_ADDR = 6'b000101 by default. The type field is payload[1:0]: 2'b10 selects status and 2'b00 selects data. payload[7:2] has no effect on an address byte.
- R4: Each transfer sends exactly eight bits, least significant first. The codec takes each bit at a rising edge of `serClk`.
- R5: Each bit cell has two halves. For HALF_CYC cycles `serClk` is low with the bit on `serData`. For the next HALF_CYC cycles `serClk` is high and `serData` holds the same value.
- R6: In the cycle after the last high half, the lines return to idle, `busy` goes to 0 and `done` is 1 for exactly one cycle.
- R7: A data request without halt keeps `serMode` high throughout. It holds `serClk` high and `serData` low for SETUP_CYC cycles before the first falling clock.
- R8: A data request with `halt`=1 first holds `serMode` low and `serClk` high for SETUP_CYC cycles. It then raises `serMode` for SETUP_CYC cycles before the first bit, and `serMode` stays high through the bits.
- R9: `busy` is 1 from the cycle after a request is taken until the lines are back at idle. A request made while `busy` is 1 has no effect.
- R10: SETUP_CYC = ceil(SETUP_NS*CLK_MHZ/1000) and HALF_CYC = ceil(CELL_NS*CLK_MHZ/2000), each at least 1. At 250 MHz this gives 48 cycles (192 ns ≥ 190 ns) and 63 cycles, a 504 ns cell (≥ 500 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start request, taken only while idle |
| isData | input | 1 | 1: data byte, 0: address byte |
| halt | input | 1 | Insert a halt condition before a data byte |
| payload | input | BYTE_W | Data byte, or type in bits [1:0] for an address byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the lines are back at idle |
| serMode | output | 1 | Mode line (low: address phase or halt) |
| serClk | output | 1 | Serial clock line |
| serData | output | 1 | Serial data line |

## Verification
The bench uses the default parameters with CLK_MHZ=250. This gives a 48-cycle setup and a 63-cycle half cell, long enough that every phase boundary is distinct and has no case where a count of 1 would hide an off-by-one. Each byte is checked cycle by cycle against a timeline built from the requirements. The bits are also read back at the serial clock's rising edges, so the bit order and the composed address byte are checked apart from the timing. A request injected in the middle of a transfer shows that requests are ignored while `busy` is 1.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HALT  = 3'd1,
    ST_SETUP = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4
  } seqState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // capture byte, lines to clk high / data low
    logic modeLow;   // pull mode line low
    logic modeHigh;  // release mode line high
    logic cellLow;   // falling clock, present next bit
    logic cellHigh;  // rising clock, bit held
    logic toIdle;    // all lines back to idle
  } lineStrobe_t;

endpackage

// File: rtl/cfg3w_datapath.sv
module cfg3w_datapath
  import cfg3w_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strobes,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              serMode,
  output logic              serClk,
  output logic              serData
);

  logic [BYTE_W-1:0] shiftReg;
  logic              modeReg;
  logic              clkReg;
  logic              dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      modeReg  <= 1'b1;
      clkReg   <= 1'b1;
      dataReg  <= 1'b0;
    end else begin
      if (strobes.load) begin
        shiftReg <= byteIn;
        clkReg   <= 1'b1;
        dataReg  <= 1'b0;
      end
      if (strobes.modeLow) begin
        modeReg <= 1'b0;
      end
      if (strobes.modeHigh) begin
        modeReg <= 1'b1;
      end
      if (strobes.cellLow) begin
        clkReg   <= 1'b0;
        dataReg  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end
      if (strobes.cellHigh) begin
        clkReg <= 1'b1;
      end
      if (strobes.toIdle) begin
        modeReg <= 1'b1;
        clkReg  <= 1'b1;
        dataReg <= 1'b0;
      end
    end
  end

  assign serMode = modeReg;
  assign serClk  = clkReg;
  assign serData = dataReg;

  // R5: the bit must not change across the rising clock edge
  a_r5_data_held_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkReg) |-> $stable(dataReg));

  // R2/R8: the mode line never moves while the clock is low
  a_r2_mode_stable_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    (!clkReg && $past(!clkReg)) |-> $stable(modeReg));

endmodule

// File: rtl/cfg3w_control.sv
module cfg3w_control
  import cfg3w_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SETUP_CYC = 48,
  parameter int HALF_CYC  = 63
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic        isData,
  input  logic        halt,
  output lineStrobe_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int MAX_CYC = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LOAD  = CNT_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(BYTE_W);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [BIT_W-1:0] bitCnt, bitCntNext;
  logic             doneNext;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stateNext  = state;
    cntNext    = cntZero ? cnt : cnt - 1'b1;
    bitCntNext = bitCnt;
    doneNext   = 1'b0;
    strobes    = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          strobes.load    = 1'b1;
          strobes.modeLow = !isData || halt;
          stateNext       = (isData && halt) ? ST_HALT : ST_SETUP;
          cntNext         = SETUP_LOAD;
          bitCntNext      = '0;
        end
      end
      ST_HALT: begin
        if (cntZero) begin
          strobes.modeHigh = 1'b1;
          stateNext        = ST_SETUP;
          cntNext          = SETUP_LOAD;
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          strobes.cellLow = 1'b1;
          stateNext       = ST_LOW;
          cntNext         = HALF_LOAD;
          bitCntNext      = bitCnt + 1'b1;
        end
      end
      ST_LOW: begin
        if (cntZero) begin
          strobes.cellHigh = 1'b1;
          stateNext        = ST_HIGH;
          cntNext          = HALF_LOAD;
        end
      end
      ST_HIGH: begin
        if (cntZero) begin
          if (bitCnt == LAST_BIT) begin
            strobes.toIdle = 1'b1;
            stateNext      = ST_IDLE;
            doneNext       = 1'b1;
          end else begin
            strobes.cellLow = 1'b1;
            stateNext       = ST_LOW;
            cntNext         = HALF_LOAD;
            bitCntNext      = bitCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      bitCnt <= bitCntNext;
      done   <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R10: the timing counter stays within the longest interval
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_CYC - 1));

  // R4: never more than BYTE_W bits launched in one transfer
  a_r4_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a busy cycle with a request does not restart the byte
  a_r9_no_reload_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && req && state != ST_HIGH) |=> busy);

endmodule

// File: rtl/cfg3w_master.sv
module cfg3w_master
  import cfg3w_pkg::*;
#(
  parameter int          CLK_MHZ  = 250,
  parameter int          SETUP_NS = 190,
  parameter int          CELL_NS  = 500,
  parameter int          BYTE_W   = 8,
  parameter int          TYPE_W   = 2,
  parameter logic [5:0]  DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              isData,
  input  logic              halt,
  input  logic [BYTE_W-1:0] payload,
  output logic              busy,
  output logic              done,
  output logic              serMode,
  output logic              serClk,
  output logic              serData
);

  localparam int SETUP_RAW = (SETUP_NS * CLK_MHZ + 999) / 1000;
  localparam int HALF_RAW  = (CELL_NS * CLK_MHZ + 1999) / 2000;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HALF_CYC  = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int DEV_W     = BYTE_W - TYPE_W;

  lineStrobe_t       strobes;
  logic [BYTE_W-1:0] byteSel;

  assign byteSel = isData ? payload
                          : {DEV_ADDR[DEV_W-1:0], payload[TYPE_W-1:0]};

  cfg3w_control #(
    .BYTE_W   (BYTE_W),
    .SETUP_CYC(SETUP_CYC),
    .HALF_CYC (HALF_CYC)
  ) u_control (
    .clk    (clk),
    .rstN   (rstN),
    .req    (req),
    .isData (isData),
    .halt   (halt),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  cfg3w_datapath #(
    .BYTE_W(BYTE_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .byteIn (byteSel),
    .serMode(serMode),
    .serClk (serClk),
    .serData(serData)
  );

  // R1: idle lines whenever not busy
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serMode && serClk && !serData));

  // R9: the clock only goes low inside a transfer
  a_r9_clk_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    !serClk |-> busy);

  // R6: done arrives with lines already idle
  a_r6_done_at_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && serMode && serClk));

  // R8: the mode line falls only together with clock high
  a_r8_mode_fall_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serMode) |-> (serClk && busy));

endmodule

// File: tb/cfg3w_master_bench.sv
`timescale 1ns/1ps
module cfg3w_master_bench;

  localparam int S = 48;  // setup cycles at 250 MHz
  localparam int H = 63;  // half-cell cycles at 250 MHz
  localparam int NVEC = 8;
  // {isData, halt, payload[7:0], expected byte[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hFE, 8'h16},
    {1'b0, 1'b0, 8'h00, 8'h14},
    {1'b1, 1'b0, 8'h50, 8'h50},
    {1'b1, 1'b1, 8'hA4, 8'hA4},
    {1'b1, 1'b0, 8'h81, 8'h81},
    {1'b0, 1'b0, 8'hA9, 8'h15},
    {1'b1, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'hFF, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic isData = 1'b0;
  logic halt = 1'b0;
  logic [7:0] payload = '0;
  logic busy, done, serMode, serClk, serData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cfg3w_master u_cfg3w_master (
    .clk(clk), .rstN(rstN), .req(req), .isData(isData), .halt(halt),
    .payload(payload), .busy(busy), .done(done),
    .serMode(serMode), .serClk(serClk), .serData(serData)
  );

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic runXfer(input logic isD, input logic hl, input logic [7:0] pl,
                         input logic [7:0] expByte, input int glitchAt);
    int off;
    int total;
    int errs;
    string firstErr;
    string tag;
    logic [7:0] got;
    int nBits;
    logic prevClk;
    logic eMode, eClk, eData, eBusy;
    tag = isD ? (hl ? "R8" : "R7") : "R2";
    off = (isD && hl) ? 2 * S : S;
    total = off + 16 * H;
    errs = 0;
    firstErr = "";
    got = '0;
    nBits = 0;
    prevClk = 1'b1;
    @(negedge clk);
    req = 1'b1; isData = isD; halt = hl; payload = pl;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < total; i++) begin
      if (i == glitchAt + 1) req = 1'b0;
      eBusy = 1'b1;
      if (i < off) begin
        eClk = 1'b1; eData = 1'b0;
        eMode = (isD && hl) ? (i >= S) : isD;
      end else begin
        int k;
        k = i - off;
        eClk = ((k / H) % 2) == 1;
        eData = expByte[k / (2 * H)];
        eMode = isD;
      end
      if ({serMode, serClk, serData, busy} !== {eMode, eClk, eData, eBusy}) begin
        if (errs == 0)
          firstErr = $sformatf("cycle %0d mode/clk/data/busy=%b%b%b%b exp %b%b%b%b",
                               i, serMode, serClk, serData, busy, eMode, eClk, eData, eBusy);
        errs++;
      end
      if (!prevClk && serClk) begin
        if (nBits < 8) got[nBits] = serData;
        nBits++;
      end
      prevClk = serClk;
      if (i == glitchAt) begin
        req = 1'b1; isData = ~isD; halt = ~hl; payload = ~pl;
      end
      @(negedge clk);
    end
    req = 1'b0;
    chk(errs == 0, $sformatf("%s/R5 waveform pl=%h: %s", tag, pl, firstErr));
    chk(got == expByte && nBits == 8,
        $sformatf("R4/R3 byte got=%h bits=%0d exp=%h bits=8", got, nBits, expByte));
    chk({serMode, serClk, serData, busy, done} == 5'b11001,
        $sformatf("R6 end mode/clk/data/busy/done=%b%b%b%b%b exp 11001",
                  serMode, serClk, serData, busy, done));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0,
        $sformatf("R6 done pulse width done=%b busy=%b exp 0 0", done, busy));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({serMode, serClk, serData, busy, done} == 5'b11000,
        $sformatf("R1 reset lines=%b%b%b busy=%b done=%b exp 110 0 0",
                  serMode, serClk, serData, busy, done));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({serMode, serClk, serData, busy} == 4'b1100,
        $sformatf("R1 idle after reset lines=%b%b%b busy=%b exp 110 0",
                  serMode, serClk, serData, busy));
    // R10: derived counts meet minimum times (4 ns period)
    chk(S * 4 >= 190 && (S - 1) * 4 < 190,
        $sformatf("R10 setup %0d ns exp >=190 and minimal", S * 4));
    chk(2 * H * 4 >= 500 && 2 * (H - 1) * 4 < 500,
        $sformatf("R10 cell %0d ns exp >=500 and minimal", 2 * H * 4));

    for (int v = 0; v < NVEC; v++) begin
      runXfer(VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0], -10);
    end

    // R9: request mid-transfer is ignored (address byte, flipped request injected)
    runXfer(1'b0, 1'b0, 8'h02, 8'h16, 300);
    // R9: request during halt phase is ignored
    runXfer(1'b1, 1'b1, 8'h3C, 8'h3C, 10);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && serMode && serClk && !serData,
        $sformatf("R9 no late start busy=%b lines=%b%b%b exp 0 110",
                  busy, serMode, serClk, serData));

    // R1: reset mid-transfer returns lines to idle
    @(negedge clk);
    req = 1'b1; isData = 1'b0; payload = 8'h00;
    @(negedge clk);
    req = 1'b0;
    repeat (60) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk({serMode, serClk, serData, busy} == 4'b1100,
        $sformatf("R1 reset mid-byte lines=%b%b%b busy=%b exp 110 0",
                  serMode, serClk, serData, busy));
    rstN = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule